// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block owns the program counter of a single-cycle 32-bit integer core and works out, every cycle, where execution goes next. It looks at the instruction word now being executed and at the two source operand values that the register file supplies for it. From these it recognises conditional branches, the PC-relative jump-and-link and the register-indirect jump-and-link. It assembles the branch and jump offsets from their scattered instruction bits and resolves the six branch conditions, both signed and unsigned. On the next rising clock edge it loads the chosen address into the PC.

Alongside the PC it drives a return-address value equal to PC + 4 and a flag that tells the register file to write that value to the destination register. The ALU result path, loads, stores, traps and 16-bit instructions are handled elsewhere. The core advances one instruction per cycle and there is no stall, so the block has no handshake. Its inputs are taken as valid in every cycle after reset, and its outputs are plain signals.

Top module: `bnpc_unit`

## Requirements
- R1: While `rst_n` is low the PC is held at 0. The first rising edge after release loads the next PC computed from the instruction and operands then present.
- R2: Any opcode other than 1100011, 1101111 or 1100111 in bits 6:0 advances the PC by 4 at the next rising edge and leaves `link_we` low.
- R3: `link_val` always equals the current PC plus 4, modulo 2^32, in the same cycle.
- R4: With opcode 1100011, funct3 (bits 14:12) 000 takes the branch when rs1 equals rs2, and 001 takes it when they differ.
- R5: With opcode 1100011, funct3 100 takes the branch when rs1 is less than rs2 as two's-complement numbers, and 101 takes it when rs1 is greater than or equal to rs2.
- R6: With opcode 1100011, funct3 110 takes the branch when rs1 is less than rs2 as unsigned numbers, and 111 takes it when rs1 is greater than or equal to rs2.
- R7: A taken branch loads PC + offset. The 13-bit offset is, from its MSB down: instruction bit 31, bit 7, bits 30:25, bits 11:8, then a zero. It is sign-extended from bit 31.
- R8: A branch whose condition fails, or whose funct3 is 010 or 011, loads PC + 4.
- R9: Opcode 1101111 raises `link_we` and loads PC + offset. The 21-bit offset is, from its MSB down: bit 31, bits 19:12, bit 20, bits 30:25, bits 24:21, then a zero. It is sign-extended.
- R10: Opcode 1100111 raises `link_we` and loads (rs1 + sign-extended bits 31:20) with bit 0 forced to 0.
- R11: `link_we` is never high for opcode 1100011, whether the branch is taken or not.
- R12: All PC arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC loads on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Instruction word at the current PC |
| rs1_val | input | 32 | First source operand value |
| rs2_val | input | 32 | Second source operand value |
| pc_q | output | 32 | Current program counter |
| link_val | output | 32 | Return address, current PC + 4 |
| link_we | output | 1 | Destination write request for the return address |

## Verification
`link_val` and `link_we` are combinational in the current instruction and PC. The bench reads them 1 ns after it drives new inputs on a falling edge. The PC passes through one register, so the effect of an instruction shows on `pc_q` after the next rising edge. The bench reads it on the falling edge that follows, with the expected value computed from the PC it recorded before that edge. Each scenario first sets the PC with a register-indirect jump, so every expected target is an absolute address that can be worked out by hand.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  typedef enum logic [2:0] {
    CND_EQ   = 3'b000,
    CND_NE   = 3'b001,
    CND_RSV2 = 3'b010,
    CND_RSV3 = 3'b011,
    CND_LT   = 3'b100,
    CND_GE   = 3'b101,
    CND_LTU  = 3'b110,
    CND_GEU  = 3'b111
  } cond_e;

  typedef enum logic [1:0] {
    NPC_SEQ,
    NPC_BRANCH,
    NPC_JAL,
    NPC_JALR
  } npc_sel_e;

endpackage

// File: rtl/bnpc_imm.sv
module bnpc_imm #(
  parameter int XLEN = 32
) (
  input  logic [31:7]     ibits,
  output logic [XLEN-1:0] imm_b,
  output logic [XLEN-1:0] imm_j,
  output logic [XLEN-1:0] imm_i
);
  localparam int BW = 13;
  localparam int JW = 21;
  localparam int IW = 12;

  logic [BW-1:0] b_raw;
  logic [JW-1:0] j_raw;
  logic [IW-1:0] i_raw;

  // offsets reassembled from their scattered fields, bit 0 always zero
  assign b_raw = {ibits[31], ibits[7], ibits[30:25], ibits[11:8], 1'b0};
  assign j_raw = {ibits[31], ibits[19:12], ibits[20], ibits[30:25], ibits[24:21], 1'b0};
  assign i_raw = ibits[31:20];

  assign imm_b = {{(XLEN-BW){b_raw[BW-1]}}, b_raw};
  assign imm_j = {{(XLEN-JW){j_raw[JW-1]}}, j_raw};
  assign imm_i = {{(XLEN-IW){i_raw[IW-1]}}, i_raw};
endmodule

// File: rtl/bnpc_cmp.sv
module bnpc_cmp
  import bnpc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit SHARED_SUB = 1'b1
) (
  input  cond_e           cond,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            take
);
  logic eq, lt_s, lt_u;

  generate
    if (SHARED_SUB) begin : g_sub
      // one subtractor with a carry bit serves all three relations
      logic [XLEN:0] diff;
      assign diff = {1'b0, a} - {1'b0, b};
      assign eq   = (diff[XLEN-1:0] == '0);
      assign lt_u = diff[XLEN];
      assign lt_s = (a[XLEN-1] ^ b[XLEN-1]) ? a[XLEN-1] : diff[XLEN];
    end else begin : g_rel
      assign eq   = (a == b);
      assign lt_u = (a < b);
      assign lt_s = ($signed(a) < $signed(b));
    end
  endgenerate

  always_comb begin
    case (cond)
      CND_EQ:  take = eq;
      CND_NE:  take = !eq;
      CND_LT:  take = lt_s;
      CND_GE:  take = !lt_s;
      CND_LTU: take = lt_u;
      CND_GEU: take = !lt_u;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/bnpc_target.sv
module bnpc_target
  import bnpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  npc_sel_e        sel,
  input  logic            take,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rs1,
  input  logic [XLEN-1:0] imm_b,
  input  logic [XLEN-1:0] imm_j,
  input  logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] pc_plus4
);
  localparam logic [XLEN-1:0] STEP      = XLEN'(4);
  localparam logic [XLEN-1:0] EVEN_MASK = {{(XLEN-1){1'b1}}, 1'b0};

  logic [XLEN-1:0] rel_off, rel_tgt, reg_tgt;

  assign pc_plus4 = pc + STEP;
  // branch and jump share one PC-relative adder
  assign rel_off  = (sel == NPC_JAL) ? imm_j : imm_b;
  assign rel_tgt  = pc + rel_off;
  assign reg_tgt  = (rs1 + imm_i) & EVEN_MASK;

  always_comb begin
    case (sel)
      NPC_BRANCH: next_pc = take ? rel_tgt : pc_plus4;
      NPC_JAL:    next_pc = rel_tgt;
      NPC_JALR:   next_pc = reg_tgt;
      default:    next_pc = pc_plus4;
    endcase
  end
endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
  import bnpc_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] RESET_PC   = '0,
  parameter bit              SHARED_SUB = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] link_val,
  output logic            link_we
);
  npc_sel_e        sel;
  logic            take;
  logic [XLEN-1:0] imm_b, imm_j, imm_i, next_pc;

  always_comb begin
    case (instr[6:0])
      OPC_BRANCH: sel = NPC_BRANCH;
      OPC_JAL:    sel = NPC_JAL;
      OPC_JALR:   sel = NPC_JALR;
      default:    sel = NPC_SEQ;
    endcase
  end

  assign link_we = (sel == NPC_JAL) || (sel == NPC_JALR);

  bnpc_imm #(.XLEN(XLEN)) u_imm (
    .ibits (instr[31:7]),
    .imm_b (imm_b),
    .imm_j (imm_j),
    .imm_i (imm_i)
  );

  bnpc_cmp #(.XLEN(XLEN), .SHARED_SUB(SHARED_SUB)) u_cmp (
    .cond (cond_e'(instr[14:12])),
    .a    (rs1_val),
    .b    (rs2_val),
    .take (take)
  );

  bnpc_target #(.XLEN(XLEN)) u_tgt (
    .sel      (sel),
    .take     (take),
    .pc       (pc_q),
    .rs1      (rs1_val),
    .imm_b    (imm_b),
    .imm_j    (imm_j),
    .imm_i    (imm_i),
    .next_pc  (next_pc),
    .pc_plus4 (link_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= next_pc;
  end
endmodule

// File: rtl/bnpc_chk.sv
module bnpc_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] rs1_val,
  input logic [XLEN-1:0] rs2_val,
  input logic [XLEN-1:0] pc_q,
  input logic [XLEN-1:0] link_val,
  input logic            link_we
);
  logic            is_br, is_jal, is_jalr;
  logic [20:0]     joff;
  logic [12:0]     boff;
  logic [XLEN-1:0] jext, bext;

  assign is_br   = (instr[6:0] == 7'b1100011);
  assign is_jal  = (instr[6:0] == 7'b1101111);
  assign is_jalr = (instr[6:0] == 7'b1100111);

  always_comb begin
    joff        = '0;
    joff[10:1]  = instr[30:21];
    joff[11]    = instr[20];
    joff[19:12] = instr[19:12];
    joff[20]    = instr[31];
    boff        = '0;
    boff[4:1]   = instr[11:8];
    boff[10:5]  = instr[30:25];
    boff[11]    = instr[7];
    boff[12]    = instr[31];
  end

  assign jext = XLEN'($signed(joff));
  assign bext = XLEN'($signed(boff));

  // R2 / R3: a plain instruction lands on the advertised return address
  p_seq_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_br && !is_jal && !is_jalr) |=> (pc_q == $past(link_val)));

  p_seq_nolink_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_br && !is_jal && !is_jalr) |-> !link_we);

  p_beq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_br && instr[14:12] == 3'b000 && rs1_val == rs2_val)
      |=> (pc_q == $past(pc_q) + $past(bext)));

  p_rsv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_br && instr[14:13] == 2'b01) |=> (pc_q == $past(pc_q) + XLEN'(4)));

  p_jal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_jal |=> (pc_q == $past(pc_q) + $past(jext)));

  p_jal_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_jal || is_jalr) |-> link_we);

  p_jalr_even_r10: assert property (@(posedge clk) disable iff (!rst_n)
    is_jalr |=> (pc_q[0] == 1'b0));

  p_br_nolink_r11: assert property (@(posedge clk) disable iff (!rst_n)
    is_br |-> !link_we);
endmodule

bind bnpc_unit bnpc_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .instr    (instr),
  .rs1_val  (rs1_val),
  .rs2_val  (rs2_val),
  .pc_q     (pc_q),
  .link_val (link_val),
  .link_we  (link_we)
);

// File: tb/bnpc_unit_bench.sv
`timescale 1ns/1ps
module bnpc_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = 32'h0000_0013;
  logic [31:0] rs1_val = '0;
  logic [31:0] rs2_val = '0;
  logic [31:0] pc_q, link_val;
  logic        link_we;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] pc_before, lv_s;
  logic        lw_s;

  localparam logic [31:0] NOP = 32'h0000_0013;

  bnpc_unit u_bnpc_unit (
    .clk(clk), .rst_n(rst_n), .instr(instr), .rs1_val(rs1_val),
    .rs2_val(rs2_val), .pc_q(pc_q), .link_val(link_val), .link_we(link_we)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] enc_b(input logic [2:0] f3, input logic [12:0] im);
    return {im[12], im[10:5], 5'd2, 5'd1, f3, im[4:1], im[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] enc_j(input logic [20:0] im);
    return {im[20], im[10:1], im[11], im[19:12], 5'd1, 7'b1101111};
  endfunction

  function automatic logic [31:0] enc_jr(input logic [11:0] im);
    return {im, 5'd3, 3'b000, 5'd1, 7'b1100111};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive on a falling edge, sample combinational outputs, then let the PC load
  task automatic run(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    instr = ins; rs1_val = a; rs2_val = b;
    #1;
    pc_before = pc_q; lw_s = link_we; lv_s = link_val;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_pc(input logic [31:0] v);
    run(enc_jr(12'h000), v, 32'h0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 pc held in reset", pc_q, 32'h0);
    chk("R3 link value in reset", link_val, 32'h4);
    rst_n = 1'b1;
    run(NOP, 0, 0);
    chk("R1 first edge after release", pc_q, 32'h4);
  endtask

  task automatic t_seq;
    run(NOP, 0, 0);
    chk("R2 plain op advances", pc_q, 32'h8);
    chk("R2 plain op no link", {31'b0, lw_s}, 32'h0);
    run(32'h0020_a023, 5, 5);
    chk("R2 store opcode advances", pc_q, 32'hC);
    chk("R3 link value tracks pc", lv_s, 32'hC);
  endtask

  task automatic t_eq;
    set_pc(32'h100);
    run(enc_b(3'b000, 13'd16), 5, 5);
    chk("R4 beq equal taken", pc_q, 32'h110);
    chk("R11 branch no link", {31'b0, lw_s}, 32'h0);
    run(enc_b(3'b000, 13'd16), 5, 6);
    chk("R4 beq unequal falls through", pc_q, 32'h114);
    run(enc_b(3'b001, -13'sd8), 5, 6);
    chk("R4 bne unequal taken backward", pc_q, 32'h10C);
    run(enc_b(3'b001, 13'd64), 7, 7);
    chk("R4 bne equal falls through", pc_q, 32'h110);
  endtask

  task automatic t_signed;
    set_pc(32'h200);
    run(enc_b(3'b100, 13'h40), 32'hFFFF_FFFF, 32'h1);
    chk("R5 blt -1<1 taken", pc_q, 32'h240);
    run(enc_b(3'b101, 13'h40), 32'hFFFF_FFFF, 32'h1);
    chk("R5 bge -1>=1 not taken", pc_q, 32'h244);
    run(enc_b(3'b101, 13'h20), 32'h8000_0000, 32'h8000_0000);
    chk("R5 bge equal taken", pc_q, 32'h264);
    chk("R11 taken branch no link", {31'b0, lw_s}, 32'h0);
    run(enc_b(3'b100, 13'h20), 32'h7FFF_FFFF, 32'h8000_0000);
    chk("R5 blt max<min not taken", pc_q, 32'h268);
  endtask

  task automatic t_unsigned;
    set_pc(32'h400);
    run(enc_b(3'b110, 13'h10), 32'hFFFF_FFFF, 32'h1);
    chk("R6 bltu big<1 not taken", pc_q, 32'h404);
    run(enc_b(3'b111, 13'h10), 32'hFFFF_FFFF, 32'h1);
    chk("R6 bgeu big>=1 taken", pc_q, 32'h414);
    run(enc_b(3'b110, 13'h100), 32'h1, 32'h2);
    chk("R6 bltu 1<2 taken", pc_q, 32'h514);
    run(enc_b(3'b111, 13'h100), 32'h0, 32'h1);
    chk("R6 bgeu 0>=1 not taken", pc_q, 32'h518);
  endtask

  task automatic t_bimm;
    set_pc(32'h2000);
    run(enc_b(3'b000, 13'h0800), 1, 1);
    chk("R7 offset bit 11 from bit 7", pc_q, 32'h2800);
    set_pc(32'h2000);
    run(enc_b(3'b000, 13'h1000), 1, 1);
    chk("R7 most negative offset", pc_q, 32'h1000);
    run(enc_b(3'b000, 13'h0FFE), 1, 1);
    chk("R7 largest positive offset", pc_q, 32'h1FFE);
    set_pc(32'h2000);
    run(enc_b(3'b010, 13'h40), 1, 1);
    chk("R8 funct3 010 never taken", pc_q, 32'h2004);
    run(enc_b(3'b011, 13'h40), 1, 2);
    chk("R8 funct3 011 never taken", pc_q, 32'h2008);
  endtask

  task automatic t_jal;
    set_pc(32'h1000);
    run(enc_j(21'h000800), 0, 0);
    chk("R9 jal offset bit 11 from bit 20", pc_q, 32'h1800);
    chk("R9 jal raises link", {31'b0, lw_s}, 32'h1);
    chk("R9 jal return address", lv_s, 32'h1004);
    run(enc_j(-21'sd2), 0, 0);
    chk("R9 jal offset -2", pc_q, 32'h17FE);
    run(enc_j(21'h012346), 0, 0);
    chk("R9 jal mixed offset", pc_q, 32'h13B44);
    run(enc_j(21'h100000), 0, 0);
    chk("R12 jal most negative wraps", pc_q, 32'hFFF1_3B44);
  endtask

  task automatic t_jalr;
    set_pc(32'h800);
    run(enc_jr(12'h000), 32'h3001, 0);
    chk("R10 jalr clears bit 0", pc_q, 32'h3000);
    chk("R10 jalr raises link", {31'b0, lw_s}, 32'h1);
    chk("R10 jalr return address", lv_s, 32'h804);
    run(enc_jr(12'hFFF), 32'h1000, 0);
    chk("R10 jalr negative imm", pc_q, 32'h0FFE);
    run(enc_jr(12'h7FF), 32'h2000, 0);
    chk("R10 jalr max imm", pc_q, 32'h27FE);
    run(enc_jr(12'h004), 32'hFFFF_FFFE, 0);
    chk("R12 jalr sum wraps", pc_q, 32'h2);
    chk("R3 link value after wrap", link_val, 32'h6);
  endtask

  initial begin
    t_reset();
    t_seq();
    t_eq();
    t_signed();
    t_unsigned();
    t_bimm();
    t_jal();
    t_jalr();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule